// File: doc/BRIEF.md
# Synchronous Burst SRAM Read Path with Selectable Output Timing

This block is the read-data and output-driver sequencer around a synchronous SRAM array. Every command (chip select, read or write, address, write data) is captured on the rising clock edge. Read data reaches the data pins in one of two ways. In flow-through mode it comes straight from the array's read register. In pipelined mode it passes through one more clocked output register.

The driver enable follows the read pipeline. After the last read's data slot it turns off in one of two ways. In single-cycle deselect the drivers drop as soon as the data slot ends. In dual-cycle deselect they stay on for one more cycle and keep showing the last word.

Two straps select the mode, and they are read only while reset is held. Tying both straps low gives the default: pipelined output with single-cycle deselect. The output enable gates the drivers with no clock involved. A sleep input blocks all commands and disables the drivers, and the array keeps its contents while asleep.

Top module: `sync_sram_rdpath`

## Requirements
- R1: With `strap_flow`=1, a read captured at rising edge k drives its word on `rdata`, with `drv_en`=1, in the cycle after edge k.
- R2: With `strap_flow`=0, a read captured at edge k drives its word in the cycle after edge k+1.
- R3: A new read may be captured on every edge. In both output modes, consecutive reads give one word per cycle with no gap cycle.
- R4: With `strap_dcd`=0, `drv_en` falls at the first edge after the last read's data slot when no read follows.
- R5: With `strap_dcd`=1, `drv_en` stays 1 for one more cycle after the last read's data slot, and `rdata` holds that last word during that cycle.
- R6: `oe`=0 forces `drv_en`=0 at once, with no clock edge needed.
- R7: While `sleep`=1, reads and writes are ignored and `drv_en`=0. Array contents written before sleep are read back unchanged afterwards.
- R8: The straps are sampled only while `rst`=1. Changing them after reset has no effect. With both straps at 0, the block runs pipelined with single-cycle deselect.
- R9: A write (`sel`=1, `wr`=1) stores `wdata` at `addr` on the capturing edge. A read of that address on the next edge returns the new word. A captured write does not turn on the drivers.
- R10: While `rst`=1, and whenever `drv_en`=0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; straps are latched while high |
| sel | input | 1 | Chip select; a command is captured on an edge when high |
| wr | input | 1 | 1 = write, 0 = read, when selected |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| strap_flow | input | 1 | 1 = flow-through output, 0 = pipelined output |
| strap_dcd | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect |
| oe | input | 1 | Output enable, gates the drivers without a clock |
| sleep | input | 1 | Low-power request; blocks commands and drivers |
| rdata | output | DW | Read data, zero while not driven |
| drv_en | output | 1 | Output driver enable |

## Verification
The bench builds the block with a 4-bit address and 8-bit data. This makes the whole 16-word array cheap to fill and check. It runs all four strap combinations, with a reset between each, so every pairing of latency and deselect depth is compared cycle by cycle against a behavioural model. In each combination it checks isolated reads, unbroken bursts, read-then-deselect endings and write-then-read turnarounds. It also changes the straps after reset, toggles the output enable in the middle of a cycle, and writes during sleep.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // Command as accepted on a clock edge.
  typedef struct packed {
    logic rd;
    logic wr;
  } srp_cmd_t;

  // Output timing selection, latched during reset.
  typedef struct packed {
    logic flow;
    logic dcd;
  } srp_mode_t;

  localparam int unsigned SRP_HIST = 3;  // read-history stages kept
endpackage

// File: rtl/srp_array.sv
module srp_array #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, synchronous read with enable: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/srp_shift.sv
module srp_shift #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  output logic [N-1:0] dout
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) dout[0] <= 1'b0;
          else     dout[0] <= din;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) dout[i] <= 1'b0;
          else     dout[i] <= dout[i-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/srp_drive.sv
module srp_drive #(
  parameter int unsigned N = 3
) (
  input  srp_pkg::srp_mode_t mode,
  input  logic [N-1:0]       rd_hist,
  input  logic               oe,
  input  logic               sleep,
  output logic               drv
);
  logic slot;
  logic hold;

  // Data slot: stage 0 in flow-through mode, stage 1 when pipelined.
  // Dual deselect keeps the drivers on for the stage after the slot.
  always_comb begin
    slot = mode.flow ? rd_hist[0] : rd_hist[1];
    hold = mode.dcd & (mode.flow ? rd_hist[1] : rd_hist[2]);
    drv  = (slot | hold) & oe & ~sleep;
  end
endmodule

// File: rtl/sync_sram_rdpath.sv
module sync_sram_rdpath #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          strap_flow,
  input  logic          strap_dcd,
  input  logic          oe,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          drv_en
);
  import srp_pkg::*;

  localparam int unsigned NH = SRP_HIST;

  srp_mode_t       mode_q;
  logic            flow_q;
  logic            dcd_q;
  srp_cmd_t        cmd;
  logic [NH-1:0]   rd_hist;
  logic [DW-1:0]   ram_q;
  logic [DW-1:0]   pipe_q;
  logic [DW-1:0]   out_word;

  // Straps are only looked at while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q.flow <= strap_flow;
      mode_q.dcd  <= strap_dcd;
    end
  end
  assign flow_q = mode_q.flow;
  assign dcd_q  = mode_q.dcd;

  // Command acceptance: blocked by reset and by sleep.
  always_comb begin
    cmd.rd = sel & ~wr & ~sleep & ~rst;
    cmd.wr = sel &  wr & ~sleep & ~rst;
  end

  srp_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .we    (cmd.wr),
    .re    (cmd.rd),
    .addr  (addr),
    .wdata (wdata),
    .rdata (ram_q)
  );

  srp_shift #(.N(NH)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .din  (cmd.rd),
    .dout (rd_hist)
  );

  // Output register, loaded one edge after the array read.
  always_ff @(posedge clk) begin
    if (rst)             pipe_q <= '0;
    else if (rd_hist[0]) pipe_q <= ram_q;
  end

  assign out_word = mode_q.flow ? ram_q : pipe_q;

  srp_drive #(.N(NH)) u_drive (
    .mode    (mode_q),
    .rd_hist (rd_hist),
    .oe      (oe),
    .sleep   (sleep),
    .drv     (drv_en)
  );

  assign rdata = drv_en ? out_word : '0;
endmodule

// File: rtl/srp_chk.sv
module srp_chk #(
  parameter int unsigned DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          sel,
  input logic          wr,
  input logic          oe,
  input logic          sleep,
  input logic          flow_m,
  input logic          dcd_m,
  input logic [DW-1:0] rdata,
  input logic          drv_en
);
  logic rdcmd;
  assign rdcmd = sel && !wr && !sleep && !rst;

  assert_flow_lat_R1: assert property (@(posedge clk) disable iff (rst)
    (flow_m && oe && !sleep && $past(rdcmd)) |-> drv_en);

  assert_pipe_lat_R2: assert property (@(posedge clk) disable iff (rst)
    (!flow_m && oe && !sleep && $past(rdcmd, 2)) |-> drv_en);

  assert_scd_flow_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!dcd_m && flow_m && !$past(rdcmd)) |-> !drv_en);

  assert_scd_pipe_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!dcd_m && !flow_m && !$past(rdcmd, 2)) |-> !drv_en);

  assert_dcd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (dcd_m && flow_m && oe && !sleep && $past(rdcmd, 2)) |-> drv_en);

  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !drv_en);

  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !drv_en);

  assert_mode_static_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ($stable(flow_m) && $stable(dcd_m)));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> (rdata == '0));
endmodule

bind sync_sram_rdpath srp_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel    (sel),
  .wr     (wr),
  .oe     (oe),
  .sleep  (sleep),
  .flow_m (flow_q),
  .dcd_m  (dcd_q),
  .rdata  (rdata),
  .drv_en (drv_en)
);

// File: tb/sync_sram_rdpath_tb.sv
`timescale 1ns/1ps
module sync_sram_rdpath_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          strap_flow = 1'b0, strap_dcd = 1'b0;
  logic          oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic          drv_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_sram_rdpath #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .strap_flow(strap_flow), .strap_dcd(strap_dcd), .oe(oe), .sleep(sleep),
    .rdata(rdata), .drv_en(drv_en)
  );

  // Behavioural reference: memory, read history and word trackers.
  logic [DW-1:0] mm [DEPTH];
  bit            m_flow, m_dcd;
  bit            h0, h1, h2;
  logic [DW-1:0] last_dat = '0;
  logic [DW-1:0] pipe_dat = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_flow = strap_flow; m_dcd = strap_dcd;
      h0 = 0; h1 = 0; h2 = 0; pipe_dat = '0;
    end else begin
      bit rc, wc;
      rc = sel && !wr && !sleep;
      wc = sel && wr && !sleep;
      if (h0) pipe_dat = last_dat;
      h2 = h1; h1 = h0; h0 = rc;
      if (rc) last_dat = mm[addr];
      if (wc) mm[addr] = wdata;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle compare in the middle of every clock period.
  always @(negedge clk) begin
    if (chk_en) begin
      bit slot, hold, e_drv;
      logic [DW-1:0] e_dat;
      slot  = m_flow ? h0 : h1;
      hold  = m_dcd && (m_flow ? h1 : h2);
      e_drv = (slot || hold) && oe && !sleep;
      e_dat = e_drv ? (m_flow ? last_dat : pipe_dat) : '0;
      check(drv_en === e_drv, {cur_req, " drv_en"}, drv_en, e_drv);
      check(rdata === e_dat, {cur_req, " rdata"}, rdata, e_dat);
    end
  end

  task automatic step(input bit s, input bit w, input int a, input int d);
    sel = s; wr = w; addr = a[AW-1:0]; wdata = d[DW-1:0];
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic do_reset(input bit f, input bit d);
    strap_flow = f; strap_dcd = d; rst = 1'b1;
    cur_req = "R10";
    idle(3);
    check(drv_en === 1'b0 && rdata === '0, "R10 reset outputs", {drv_en, rdata}, 0);
    rst = 1'b0;
  endtask

  task automatic run_mode(input bit f, input bit d);
    do_reset(f, d);
    cur_req = f ? "R1" : "R2";
    step(1, 0, 3, 0); idle(4);
    step(1, 0, 9, 0); idle(4);
    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(1, 0, i + 5, 0);
    idle(4);
    cur_req = d ? "R5" : "R4";
    step(1, 0, 2, 0); step(0, 0, 0, 0); idle(3);
    step(1, 0, 7, 0); step(1, 0, 8, 0); idle(4);
    cur_req = "R9";
    step(1, 1, 4, 8'hA0 + 16 * f + d); step(1, 0, 4, 0);
    step(1, 0, 6, 0); step(1, 1, 6, 8'h5C); step(1, 0, 6, 0); idle(4);
    // Asynchronous enable, checked between edges.
    cur_req = "R6";
    step(1, 0, 1, 0);
    if (!f) step(0, 0, 0, 0);
    check(drv_en === 1'b1, "R6 enabled before oe drop", drv_en, 1);
    oe = 1'b0; #0.5;
    check(drv_en === 1'b0 && rdata === '0, "R6 oe drop mid-cycle", drv_en, 0);
    oe = 1'b1; #0.5;
    check(drv_en === 1'b1, "R6 oe restore mid-cycle", drv_en, 1);
    idle(4);
  endtask

  initial begin
    @(posedge clk); #1;
    do_reset(0, 0);
    chk_en = 1'b1;
    // Fill the whole array first.
    cur_req = "R9";
    for (int i = 0; i < DEPTH; i++) step(1, 1, i, 8'h11 * i + 3);
    idle(2);
    run_mode(1, 0);
    run_mode(0, 0);
    run_mode(1, 1);
    run_mode(0, 1);
    // R8: default straps, then flip straps after reset; timing must not move.
    do_reset(0, 0);
    strap_flow = 1'b1; strap_dcd = 1'b1;
    cur_req = "R8";
    step(1, 0, 5, 0); step(1, 0, 6, 0); idle(4);
    step(1, 0, 10, 0); idle(4);
    strap_flow = 1'b0; strap_dcd = 1'b0;
    // R7: sleep blocks commands and drivers, contents retained.
    do_reset(1, 0);
    cur_req = "R7";
    sleep = 1'b1;
    step(1, 1, 3, 8'hEE); step(1, 0, 3, 0); step(1, 1, 12, 8'hDD); idle(2);
    check(drv_en === 1'b0, "R7 drivers off in sleep", drv_en, 0);
    sleep = 1'b0;
    step(1, 0, 3, 0);
    check(rdata === mm[3] && rdata !== 8'hEE, "R7 retained word", rdata, mm[3]);
    step(1, 0, 12, 0);
    check(rdata === mm[12] && rdata !== 8'hDD, "R7 retained word", rdata, mm[12]);
    idle(3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule